// File: doc/BRIEF.md
# Input Change Interrupt with Alert Response

This block watches a wide bank of general-purpose input pins and drives one active-low interrupt line. That line can also act as an SMBus alert. The pins are split into byte-wide banks. Each pin passes through a two-flop synchroniser. Each bank is compared with a snapshot of the same bank, and the snapshot is refreshed whenever the host reads that bank. A per-bit mask keeps selected pins from raising the line. A bank is pending while any of its unmasked synchronised bits differs from its snapshot.

The interrupt stays asserted while any bank is pending. A host that reads the banks in order therefore releases the line only when it reads the highest bank that holds a change. When the line is used as an alert, the block answers an Alert Response Address read. It acknowledges the address and offers its own 7-bit address as the data byte. Once the byte has gone out without losing arbitration, it releases the alert. The block takes decoded events from an I2C front end: per-bank read acknowledges, the received address byte, and the "data byte sent" and "arbitration lost" indications. It does not contain the bit engine.

Top module: `gpio_chg_alert`

## Requirements
- R1: After reset, `int_n` is high and stays high while the pins hold their reset-time values, even when those values are nonzero.
- R2: Take a pin change applied before clock edge k. If the bit is unmasked, `int_n` is still high after edge k and low after edge k+1.
- R3: A pulse on `rd_ack[b]` makes bank b's current synchronised value its new snapshot, from the next edge. `int_n` stays low while another bank still differs. Example: bits in banks 2 and 4 change together and the banks are read 0 to 4. `int_n` is still low after the read of bank 2 and high after the read of bank 4.
- R4: If a changed bit returns to its snapshot value before its bank is read, that bank stops pending and `int_n` goes high again with no read.
- R5: Pin bit b*8+i is masked by `mask[b*8+i]` = 1. A masked bit never pulls `int_n` low. Clearing the mask later raises nothing for changes made while the bit was masked.
- R6: `in_val` carries the synchronised pins, bit for bit, two edges after a pin change.
- R7: When `addr_ev` is high with `addr_byte` = 8'h19 (address 0001100, read bit 1) and `int_n` is low, `ara_ack` is high in the same cycle and `ara_data` = {`dev_addr`, 1'b0}. For any other byte, or while `int_n` is high, `ara_ack` is low.
- R8: After an acknowledged alert response, a pulse on `ara_sent` with `ara_lost` low sets `int_n` high from the next edge, even with banks still pending. New changes inside banks that are already pending keep it high.
- R9: If `ara_lost` is high with the `ara_sent` pulse, `int_n` stays low.
- R10: After an alert release, a bank that newly becomes pending pulls `int_n` low again. Pin change before edge k, low after edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 40 | Asynchronous input pins, bank b in bits b*8+7..b*8 |
| mask | input | 40 | Per-bit interrupt mask, 1 = masked |
| rd_ack | input | 5 | One-cycle pulse on the read acknowledge of each bank |
| dev_addr | input | 7 | Own 7-bit bus address |
| addr_ev | input | 1 | Address byte received strobe |
| addr_byte | input | 8 | Received address byte including direction bit |
| ara_sent | input | 1 | Alert response data byte has been shifted out |
| ara_lost | input | 1 | Arbitration lost during that byte (valid with ara_sent) |
| in_val | output | 40 | Synchronised pin values for input reads |
| int_n | output | 1 | Active-low interrupt / alert |
| ara_ack | output | 1 | Acknowledge the alert response address |
| ara_data | output | 8 | Byte to return in the alert response |

## Verification
Each result has its own latency. `int_n` and `in_val` follow a pin change after two clock edges. A re-arm after an alert release takes three. A bank read, an alert win or a lost arbitration takes effect at the very next edge. `ara_ack` and `ara_data` are valid in the same cycle as the address strobe. The bench drives all inputs on the falling edge and samples on a later falling edge, counted for each case. Exact-latency cases are checked one edge early and then on time. Random steps wait three edges before comparing with a model built from the snapshot and mask rules.

// File: rtl/gpio_chg_alert.sv
module gpio_chg_alert #(
  parameter int NBANK = 5,
  parameter int BW = 8,
  parameter logic [6:0] ARA_ADDR = 7'h0C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NBANK*BW-1:0] pin_in,
  input  logic [NBANK*BW-1:0] mask,
  input  logic [NBANK-1:0]    rd_ack,
  input  logic [6:0]          dev_addr,
  input  logic                addr_ev,
  input  logic [7:0]          addr_byte,
  input  logic                ara_sent,
  input  logic                ara_lost,
  output logic [NBANK*BW-1:0] in_val,
  output logic                int_n,
  output logic                ara_ack,
  output logic [7:0]          ara_data
);
  localparam int W = NBANK * BW;

  logic [W-1:0] sync1, sync2, snap, diff, ld;
  logic [NBANK-1:0] pend, pend_q, newp;
  logic [1:0] settle;
  logic settled, claim, rel, win;

  assign settled = &settle;
  assign diff    = (sync2 ^ snap) & ~mask;
  assign newp    = pend & ~pend_q;
  assign in_val  = sync2;
  assign int_n   = !(settled && (|pend) && !rel);
  assign ara_ack = addr_ev && (addr_byte == {ARA_ADDR, 1'b1}) && !int_n;
  assign ara_data = {dev_addr, 1'b0};
  assign win     = claim && ara_sent && !ara_lost;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign pend[b] = |diff[b*BW +: BW];

    a_r3_read_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ack[b] |=> snap[b*BW +: BW] == $past(sync2[b*BW +: BW]));

    a_r5_masked_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (&mask[b*BW +: BW]) |=> snap[b*BW +: BW] == $past(sync2[b*BW +: BW]));
  end

  always_comb begin
    for (int b = 0; b < NBANK; b++)
      ld[b*BW +: BW] = {BW{rd_ack[b] | !settled}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      snap   <= '0;
      settle <= '0;
      pend_q <= '0;
      claim  <= 1'b0;
      rel    <= 1'b0;
    end else begin
      sync1  <= pin_in;
      sync2  <= sync1;
      snap   <= (snap & ~ld & ~mask) | (sync2 & (ld | mask));
      if (!settled) settle <= settle + 2'd1;
      pend_q <= settled ? pend : '0;
      if (ara_sent)     claim <= 1'b0;
      else if (ara_ack) claim <= 1'b1;
      if ((|newp) || !(|pend)) rel <= 1'b0;
      else if (win)            rel <= 1'b1;
    end
  end

  a_r8_win_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (win && !(|newp)) |=> int_n);

  a_r9_lost_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && ara_sent && ara_lost && !rel) |=> !rel);

  a_r10_new_bank_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (|newp) |=> !rel);

endmodule

// File: tb/sim_gpio_chg_alert.sv
module sim_gpio_chg_alert;
  logic clk = 0, rst_n = 0;
  logic [39:0] pins = 40'h00_00_00_00_A5, msk = '0;
  logic [4:0] rd = '0;
  logic [6:0] dev_addr = 7'h2A;
  logic addr_ev = 0, ara_sent = 0, ara_lost = 0;
  logic [7:0] addr_byte = '0;
  logic [39:0] in_val;
  logic int_n, ara_ack;
  logic [7:0] ara_data;

  logic [39:0] snap_m;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_chg_alert u0 (.clk, .rst_n, .pin_in(pins), .mask(msk), .rd_ack(rd), .dev_addr,
    .addr_ev, .addr_byte, .ara_sent, .ara_lost, .in_val, .int_n, .ara_ack, .ara_data);

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic exp_int();
    logic [39:0] d;
    d = (pins ^ snap_m) & ~msk;
    return !(|d);
  endfunction

  task automatic track();
    snap_m = (snap_m & ~msk) | (pins & msk);
  endtask

  task automatic rdbank(int b);
    rd[b] = 1'b1;
    tick(1);
    rd = '0;
    snap_m[b*8 +: 8] = pins[b*8 +: 8];
  endtask

  task automatic ara_addr(logic [7:0] a);
    addr_ev = 1'b1; addr_byte = a;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    tick(2);
    rst_n = 1;
    tick(5);
    snap_m = pins;
    chk("R1 int_n after reset", int_n, 1);
    chk("R6 in_val", in_val, pins);

    // R2 exact latency, banks 2 and 4
    pins[2*8+3] ^= 1'b1; pins[4*8+7] ^= 1'b1;
    tick(1);
    chk("R2 int_n one edge", int_n, 1);
    tick(1);
    chk("R2 int_n two edges", int_n, 0);
    chk("R6 in_val after change", in_val, pins);

    // R3 ordered read
    for (int b = 0; b < 5; b++) begin
      rdbank(b);
      if (b == 2) chk("R3 after bank 2", int_n, 0);
      if (b == 4) chk("R3 after bank 4", int_n, 1);
    end

    // R4 change and return
    pins[1*8+5] ^= 1'b1; tick(2);
    chk("R4 change seen", int_n, 0);
    pins[1*8+5] ^= 1'b1; tick(2);
    chk("R4 returned", int_n, 1);

    // R5 mask
    msk[3*8 +: 8] = 8'hFF; tick(1); track();
    pins[3*8 +: 8] ^= 8'h3C; tick(3); track();
    chk("R5 masked change", int_n, 1);
    msk = '0; tick(3);
    chk("R5 unmask no stale", int_n, 1);

    // R7 / R9 / R8 / R10
    pins[0] ^= 1'b1; tick(3);
    chk("R7 setup pending", int_n, 0);
    ara_addr(8'h18);
    chk("R7 write dir no ack", ara_ack, 0);
    ara_addr(8'h19);
    chk("R7 ack", ara_ack, 1);
    chk("R7 data", ara_data, 8'h54);
    tick(1); addr_ev = 0;
    ara_sent = 1; ara_lost = 1; tick(1); ara_sent = 0; ara_lost = 0;
    chk("R9 lost keeps alert", int_n, 0);
    ara_addr(8'h19); tick(1); addr_ev = 0;
    ara_sent = 1; tick(1); ara_sent = 0;
    chk("R8 win releases", int_n, 1);
    pins[3] ^= 1'b1; tick(3);
    chk("R8 same bank stays released", int_n, 1);
    pins[1*8+2] ^= 1'b1; tick(2);
    chk("R10 not yet", int_n, 1);
    tick(1);
    chk("R10 new bank rearms", int_n, 0);
    rdbank(0); rdbank(1);
    chk("R3 all read", int_n, 1);
    ara_addr(8'h19);
    chk("R7 no ack when idle", ara_ack, 0);
    addr_ev = 0;
    tick(1);

    // random mix, no alert traffic
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 5);
      if (op <= 2) pins ^= {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
      else if (op == 3) msk[$urandom_range(0, 4)*8 +: 8] = 8'($urandom);
      else rdbank($urandom_range(0, 4));
      tick(3); track();
      chk("R2 R3 R5 random int_n", int_n, exp_int());
      chk("R6 random in_val", in_val, pins);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule